// File: doc/BRIEF.md
# Transmit Slot Guardian

This block sits between one node's transmitter and the shared broadcast medium. It runs from its own clock and counts its own ticks from the start of each communication round. It also holds its own copy of the node's transmit window: where the window starts, how long it lasts, and a guard margin on each side. The node's transmit-enable and data reach the medium only while that window is open. At every other time the path is cut, so a frame the node sends out of turn never reaches the bus.

A round-start pulse restarts the tick count. Until the first such pulse after reset, nothing passes. If the node asks to drive the bus while the gate is closed, a sticky violation flag is set, and it stays set until it is cleared. A continuous transmission is also cut off after a fixed maximum number of cycles, so a node cannot hold the medium for longer than one slot, even when the window has been configured too wide.

Top module: `slot_guard`

## Requirements
- R1: After reset, `bus_txen` is 0 and `viol` is 0. The path stays closed whatever `node_txen` does until the first cycle after a `round_start` pulse has been sampled.
- R2: The tick is 0 in the cycle after a sampled `round_start`. It then rises by one each clock.
- R3: The window is open when lo ≤ tick < start + len + margin. Here lo is start − margin, or 0 when margin exceeds start.
- R4: While the gate is open, `bus_txen` equals `node_txen` in the same cycle, and `bus_txd` equals `node_txd` whenever `bus_txen` is 1.
- R5: Whenever `bus_txen` is 0, `bus_txd` is at the idle level 1.
- R6: If `node_txen` is 1 while the gate is closed (not yet synchronised, outside the window, or over-length), `viol` is 1 from the next cycle. It then holds.
- R7: `cfg_clr` clears `viol` in the next cycle, unless a new violation occurs in the same cycle, which takes priority.
- R8: An unbroken run of `node_txen` passes to the bus for at most MAX_ON = 64 cycles. After that the gate stays closed until `node_txen` drops for at least one cycle.
- R9: A cycle with `cfg_we` loads start, len and margin. The new window applies from the next cycle.
- R10: Without `round_start`, the tick saturates at 2^CNT_W − 1 (1023 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Guardian's own clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| round_start | input | 1 | Round-start resynchronisation pulse |
| cfg_we | input | 1 | Load window configuration |
| cfg_start | input | CNT_W | Window start tick |
| cfg_len | input | CNT_W | Window length in ticks |
| cfg_margin | input | MW | Guard margin in ticks |
| cfg_clr | input | 1 | Clear the violation flag |
| node_txen | input | 1 | Node's transmit-enable |
| node_txd | input | 1 | Node's transmit data |
| bus_txen | output | 1 | Gated transmit-enable to the medium |
| bus_txd | output | 1 | Gated transmit data to the medium |
| viol | output | 1 | Sticky violation flag |

## Verification
The gating outputs are combinational from the node inputs and respond in the same cycle. The tick restart, a configuration load, a new violation and a clear all take effect one clock later. The bench sets its inputs one time unit after the rising edge and compares all three outputs at the falling edge of the same cycle. Its reference model advances only at the rising edge, so each result is checked in exactly the cycle it is due. The scenarios cover the margin clamp at tick 0, saturation near the top of the tick range, and a held transmission longer than MAX_ON.

// File: rtl/slot_guard.sv
module slot_guard #(
  parameter int CNT_W      = 10,
  parameter int MW         = 4,
  parameter int MAX_ON     = 64,
  parameter int RST_START  = 100,
  parameter int RST_LEN    = 40,
  parameter int RST_MARGIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             round_start,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_len,
  input  logic [MW-1:0]    cfg_margin,
  input  logic             cfg_clr,
  input  logic             node_txen,
  input  logic             node_txd,
  output logic             bus_txen,
  output logic             bus_txd,
  output logic             viol
);
  localparam int OW = $clog2(MAX_ON + 1);
  localparam int HW = CNT_W + 2;
  localparam logic [CNT_W-1:0] TMAX = '1;

  logic             synced;
  logic [CNT_W-1:0] tick, s_q, l_q;
  logic [MW-1:0]    m_q;
  logic [OW-1:0]    on_q;
  logic [HW-1:0]    s_x, m_x, t_x, lo, hi;
  logic             win, over, open_base, allow, bad;

  assign s_x       = HW'(s_q);
  assign m_x       = HW'(m_q);
  assign t_x       = HW'(tick);
  assign lo        = (s_x >= m_x) ? s_x - m_x : '0;
  assign hi        = s_x + HW'(l_q) + m_x;
  assign win       = (t_x >= lo) && (t_x < hi);
  assign over      = (on_q == OW'(MAX_ON));
  assign open_base = synced & win;
  assign allow     = open_base & ~over;
  assign bad       = node_txen & ~allow;

  assign bus_txen = node_txen & allow;
  assign bus_txd  = bus_txen ? node_txd : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced <= 1'b0;
      tick   <= '0;
      s_q    <= CNT_W'(RST_START);
      l_q    <= CNT_W'(RST_LEN);
      m_q    <= MW'(RST_MARGIN);
      on_q   <= '0;
      viol   <= 1'b0;
    end else begin
      if (round_start) begin
        synced <= 1'b1;
        tick   <= '0;
      end else if (tick != TMAX) begin
        tick <= tick + 1'b1;
      end
      if (cfg_we) begin
        s_q <= cfg_start;
        l_q <= cfg_len;
        m_q <= cfg_margin;
      end
      if (!node_txen)              on_q <= '0;
      else if (open_base && !over) on_q <= on_q + 1'b1;
      if (bad)          viol <= 1'b1;
      else if (cfg_clr) viol <= 1'b0;
    end
  end

  // R1
  closed_until_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !bus_txen);
  // R2
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_start |=> (tick == '0));
  // R5
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_txen |-> bus_txd);
  // R6
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_txen && !bus_txen) |=> viol);
  // R6
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !cfg_clr) |=> viol);
  // R7
  viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clr && !(node_txen && !bus_txen)) |=> !viol);
  // R8
  over_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over |-> !bus_txen);
  // R10
  tick_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == TMAX && !round_start) |=> (tick == TMAX));
endmodule

// File: tb/sim_slot_guard.sv
module sim_slot_guard;
  localparam int CLK_P  = 10;
  localparam int MAX_ON = 64;
  localparam int TMAXI  = 1023;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rs = 1'b0, we = 1'b0, clr = 1'b0, tx = 1'b0, td = 1'b0;
  logic [9:0] cst = '0, cln = '0;
  logic [3:0] cmg = '0;
  logic bus_txen, bus_txd, viol;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string ph = "R1";

  int m_tick = 0, m_on = 0, m_st = 100, m_ln = 40, m_mg = 2;
  bit m_sync = 1'b0, m_viol = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  slot_guard u0 (
    .clk(clk), .rst_n(rst_n), .round_start(rs), .cfg_we(we),
    .cfg_start(cst), .cfg_len(cln), .cfg_margin(cmg), .cfg_clr(clr),
    .node_txen(tx), .node_txd(td),
    .bus_txen(bus_txen), .bus_txd(bus_txd), .viol(viol)
  );

  function automatic bit m_win();
    int lo;
    lo = (m_st >= m_mg) ? m_st - m_mg : 0;
    return (m_tick >= lo) && (m_tick < m_st + m_ln + m_mg);
  endfunction

  task automatic cmp(string what, logic act, logic exp, string why);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s %s act=%b exp=%b t=%0t", ph, why, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit w, al, e_en, e_d;
    string why;
    @(negedge clk);
    w    = m_win();
    al   = m_sync && w && (m_on < MAX_ON);
    e_en = tx && al;
    e_d  = e_en ? td : 1'b1;
    why  = !m_sync ? "R1" : (!w ? "R3" : ((m_on >= MAX_ON) ? "R8" : "R4"));
    cmp("bus_txen", bus_txen, e_en, why);
    cmp("bus_txd", bus_txd, e_d, e_en ? "R4" : "R5");
    cmp("viol", viol, m_viol, "R6/R7");
    @(posedge clk);
    if (tx && !al) m_viol = 1'b1;
    else if (clr)  m_viol = 1'b0;
    if (!tx) m_on = 0;
    else if (m_sync && w && m_on < MAX_ON) m_on++;
    if (rs) begin m_tick = 0; m_sync = 1'b1; end
    else if (m_tick < TMAXI) m_tick++;
    if (we) begin m_st = cst; m_ln = cln; m_mg = cmg; end
    #1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic cfg(int s, int l, int m);
    cst = 10'(s); cln = 10'(l); cmg = 4'(m); we = 1'b1;
    cyc();
    we = 1'b0;
  endtask

  task automatic pulse();
    rs = 1'b1; cyc(); rs = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    ph = "R1"; run(4);
    tx = 1'b1; td = 1'b0; run(5);
    tx = 1'b0;
    ph = "R7"; clr = 1'b1; cyc(); clr = 1'b0; run(2);

    ph = "R9"; cfg(20, 10, 3);
    ph = "R2"; pulse();
    ph = "R3";
    for (int i = 0; i < 40; i++) begin tx = 1'b1; td = i[0]; cyc(); end
    tx = 1'b0; run(2);
    ph = "R7"; tx = 1'b1; clr = 1'b1; cyc(); tx = 1'b0; cyc(); clr = 1'b0; run(2);

    ph = "R2"; pulse();
    for (int i = 0; i < 30; i++) begin tx = (i % 3) != 0; td = i[1]; cyc(); end
    ph = "R2"; pulse();
    for (int i = 0; i < 10; i++) begin tx = 1'b1; td = i[0]; cyc(); end
    tx = 1'b0;

    ph = "R3"; cfg(2, 4, 5); clr = 1'b1; cyc(); clr = 1'b0; pulse();
    for (int i = 0; i < 16; i++) begin tx = 1'b1; td = ~i[0]; cyc(); end
    tx = 1'b0; clr = 1'b1; cyc(); clr = 1'b0;

    ph = "R8"; cfg(5, 200, 0); pulse(); run(6);
    tx = 1'b1;
    for (int i = 0; i < 80; i++) begin td = i[2]; cyc(); end
    tx = 1'b0; cyc(); tx = 1'b1; run(10); tx = 1'b0; run(2);
    clr = 1'b1; cyc(); clr = 1'b0;

    ph = "R10"; cfg(1000, 10, 0); pulse(); run(995);
    for (int i = 0; i < 30; i++) begin tx = i[0]; td = i[1]; cyc(); end
    tx = 1'b0; clr = 1'b1; cyc(); clr = 1'b0;
    cfg(1020, 10, 0); run(20);
    tx = 1'b1; run(8); tx = 1'b0; run(2);

    ph = "R9"; cfg(50, 5, 1); pulse(); run(45);
    for (int i = 0; i < 12; i++) begin tx = 1'b1; td = i[0]; cyc(); end
    tx = 1'b0; run(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule